// File: doc/BRIEF.md
# Byte-parallel HDLC transmit formatter

This block turns a stream of message bytes into a serial HDLC bit stream. It runs on one bit clock and sends one bit on `txd` in every cycle. When it needs the next byte it raises `byte_req` for one cycle. On that clock edge it samples the data byte and two control inputs, `msg_ctl` and `fcs_ctl`. Together these two controls choose what the next byte slot carries: an idle flag, a data byte, a byte of the frame check sequence, or an abort.

The block shifts each byte out least significant bit first. After five ones in a row inside the data and FCS fields it inserts a zero. It accumulates a 16-bit or 32-bit CRC over the data, chosen by `crc32_sel`, and appends its complement. After the last FCS byte it adds a closing flag on its own. The strobe is held back while a stuffed zero or such an automatic flag is being sent, so the interval between requests tracks the real line occupancy.

Top module: `hdlc_byte_tx`

## Requirements
- R1: At a request with `msg_ctl` and `fcs_ctl` both low, the slot carries the flag 0x7E, sent as bits 0,1,1,1,1,1,1,0 in that order, with no stuffing.
- R2: At a request with `msg_ctl` high and `fcs_ctl` low outside a frame, a frame starts: the sampled `din` is its first data byte, and the flag sent just before serves as the opening flag. Each later request in the frame takes one more byte from `din`.
- R3: Every data byte is sent least significant bit first: `din[0]` goes out on the first `txd` cycle after the sampling edge.
- R4: Within data and FCS bytes, a 0 is inserted after every run of five 1 bits. The run count carries across byte boundaries, and the zero is inserted even when the run ends on the last bit of a byte. Flag and abort patterns are never stuffed.
- R5: With the 16-bit width selected, the FCS uses x^16+x^12+x^5+1. The register starts at all ones and the complement is sent, with the coefficient of x^15 first.
- R6: With the 32-bit width selected, the FCS uses x^32+x^26+x^23+x^22+x^16+x^12+x^11+x^10+x^8+x^7+x^5+x^4+x^2+x+1. It has the same preset, complement and sending order, with the x^31 coefficient first.
- R7: Requests with both controls high inside a frame each send the next FCS byte. After the 2nd FCS byte (16-bit) or the 4th (32-bit), a closing flag follows without a request and the frame ends.
- R8: At a request with `msg_ctl` low and `fcs_ctl` high, the slot carries 0x7F (seven ones, then a zero) unstuffed. An automatic flag follows without a request, and the block leaves any frame.
- R9: `byte_req` is a one-cycle pulse. The number of cycles from one request to the next equals the number of bits the earlier slot put on the line, counting stuffed zeros and automatic flags.
- R10: During reset `txd` is high and `byte_req` is low. After reset one flag is sent before the first request.
- R11: The CRC width is taken from `crc32_sel` at the first data byte of a frame. Changes later in the same frame have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| crc32_sel | input | 1 | 1 selects the 32-bit FCS, 0 the 16-bit FCS (taken at frame start) |
| msg_ctl | input | 1 | Message control, sampled at a request |
| fcs_ctl | input | 1 | FCS control, sampled at a request |
| din | input | 8 | Data byte, sampled at a request |
| byte_req | output | 1 | One-cycle request for the next slot's controls and byte |
| txd | output | 1 | Serial HDLC output |

## Verification
The bench compares every slot's serial bits and the spacing between requests against a reference model. Runs of 0xFF bytes drive stuffing across byte boundaries and into the FCS. Repeated 0x7E data bytes show that data which looks like a flag is still stuffed. Random bytes in both CRC widths separate the two polynomials, and a width select that is toggled mid-frame shows that only the first-byte value counts. Aborts at random positions, back-to-back frames with no idle slot between them, and single-byte frames exercise the automatic flags and the gaps they open in the request stream.

// File: rtl/hdlc_byte_tx.sv
module hdlc_byte_tx #(
  parameter logic [7:0]  FLAG_PAT  = 8'h7E,
  parameter logic [7:0]  ABORT_PAT = 8'h7F,
  parameter int          RUN_LIMIT = 5,
  parameter logic [15:0] POLY16_R  = 16'h8408,
  parameter logic [31:0] POLY32_R  = 32'hEDB88320
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       crc32_sel,
  input  logic       msg_ctl,
  input  logic       fcs_ctl,
  input  logic [7:0] din,
  output logic       byte_req,
  output logic       txd
);
  localparam int CW = $clog2(RUN_LIMIT + 1);
  localparam logic [CW-1:0] RUN_V = CW'(RUN_LIMIT);

  typedef enum logic [2:0] {K_FLAG, K_FORCED, K_ABORT, K_DATA, K_FCS} kind_t;

  logic [7:0]    sh;
  logic [2:0]    left;
  logic          stuffen;
  logic [CW-1:0] ones;
  logic          force_flag, inframe, in_fcs, sel32;
  logic [1:0]    fcs_idx, fcs_last;
  logic [31:0]   crc, crc_sh;
  logic          stuff_now;
  kind_t         kind;
  logic [7:0]    pat;
  logic          pat_st;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] b,
                                           input logic w32);
    logic [31:0] r;
    logic        fb;
    r = c;
    for (int i = 0; i < 8; i++) begin
      fb = r[0] ^ b[i];
      r  = r >> 1;
      if (fb) r = r ^ (w32 ? POLY32_R : {16'h0000, POLY16_R});
    end
    return r;
  endfunction

  assign stuff_now = stuffen && (ones == RUN_V);
  assign byte_req  = !stuff_now && (left == 3'd0) && !force_flag;
  assign fcs_last  = sel32 ? 2'd3 : 2'd1;
  assign crc_sh    = crc >> {fcs_idx, 3'b000};

  always_comb begin
    if (force_flag)                     kind = K_FORCED;
    else if (!msg_ctl)                  kind = fcs_ctl ? K_ABORT : K_FLAG;
    else if (inframe && (fcs_ctl || in_fcs)) kind = K_FCS;
    else if (fcs_ctl)                   kind = K_FLAG;
    else                                kind = K_DATA;
  end

  always_comb begin
    pat    = FLAG_PAT;
    pat_st = 1'b0;
    case (kind)
      K_ABORT: pat = ABORT_PAT;
      K_FCS:   begin pat = ~crc_sh[7:0]; pat_st = 1'b1; end
      K_DATA:  begin pat = din;          pat_st = 1'b1; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txd        <= 1'b1;
      sh         <= '0;
      left       <= '0;
      stuffen    <= 1'b0;
      ones       <= '0;
      force_flag <= 1'b1;
      inframe    <= 1'b0;
      in_fcs     <= 1'b0;
      fcs_idx    <= '0;
      sel32      <= 1'b0;
      crc        <= '1;
    end else if (stuff_now) begin
      txd  <= 1'b0;
      ones <= '0;
    end else if (left != 3'd0) begin
      txd  <= sh[0];
      sh   <= {1'b0, sh[7:1]};
      left <= left - 1'b1;
      ones <= (stuffen && sh[0]) ? ones + 1'b1 : '0;
    end else begin
      txd        <= pat[0];
      sh         <= {1'b0, pat[7:1]};
      left       <= 3'd7;
      stuffen    <= pat_st;
      ones       <= (pat_st && pat[0]) ? ones + 1'b1 : '0;
      force_flag <= 1'b0;
      case (kind)
        K_FLAG: begin
          inframe <= 1'b0; in_fcs <= 1'b0; fcs_idx <= '0;
        end
        K_ABORT: begin
          inframe <= 1'b0; in_fcs <= 1'b0; fcs_idx <= '0; force_flag <= 1'b1;
        end
        K_FCS: begin
          if (fcs_idx == fcs_last) begin
            force_flag <= 1'b1; inframe <= 1'b0; in_fcs <= 1'b0; fcs_idx <= '0;
          end else begin
            in_fcs  <= 1'b1;
            fcs_idx <= fcs_idx + 1'b1;
          end
        end
        K_DATA: begin
          inframe <= 1'b1;
          if (!inframe) begin
            sel32 <= crc32_sel;
            crc   <= crc_step(crc32_sel ? 32'hFFFF_FFFF : 32'h0000_FFFF, din, crc32_sel);
          end else begin
            crc   <= crc_step(crc, din, sel32);
          end
        end
        default: ;
      endcase
    end
  end

  assert_idle_flag_R1: assert property (@(posedge clk) disable iff (!rst_n)
    byte_req && !msg_ctl && !fcs_ctl |=> !txd);

  assert_data_lsb_R3: assert property (@(posedge clk) disable iff (!rst_n)
    byte_req && kind == K_DATA |=> txd == $past(din[0]));

  assert_stuff_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stuffen && ones == RUN_V |=> !txd);

  assert_run_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ones <= RUN_V);

  assert_fcs_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_fcs |-> (fcs_idx != 2'd0) && (fcs_idx <= fcs_last));

  assert_abort_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    byte_req && !msg_ctl && fcs_ctl |=> txd);

  assert_req_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    byte_req |=> !byte_req);
endmodule

// File: tb/hdlc_byte_tx_test.sv
module hdlc_byte_tx_test;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       crc32_sel = 1'b0, msg_ctl = 1'b0, fcs_ctl = 1'b0;
  logic [7:0] din = 8'h00;
  logic       byte_req, txd;

  hdlc_byte_tx uut (
    .clk(clk), .rst_n(rst_n), .crc32_sel(crc32_sel), .msg_ctl(msg_ctl),
    .fcs_ctl(fcs_ctl), .din(din), .byte_req(byte_req), .txd(txd)
  );

  always #2 clk = ~clk;

  typedef struct packed { logic m; logic f; logic s; logic [7:0] d; } cmd_t;
  cmd_t cmds[$];
  cmd_t c;

  int checks = 0, errors = 0;
  logic [31:0] m_crc = 32'hFFFF_FFFF;
  int m_w = 16, m_ones = 0, m_fidx = 0;
  bit m_inframe = 0, m_infcs = 0;
  logic [31:0] exp_v, got_v;
  int exp_n, got_n = 0;
  string exp_tag;
  bit run = 0, done = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic put(input logic b, input bit st);
    if (exp_n < 32) exp_v[exp_n] = b;
    exp_n++;
    if (st) begin
      if (b) m_ones++; else m_ones = 0;
      if (m_ones == 5) begin
        if (exp_n < 32) exp_v[exp_n] = 1'b0;
        exp_n++;
        m_ones = 0;
      end
    end else m_ones = 0;
  endtask

  task automatic put_byte(input logic [7:0] v, input bit st);
    for (int i = 0; i < 8; i++) put(v[i], st);
  endtask

  task automatic crc_bit(input logic b);
    logic fb;
    fb = m_crc[m_w-1] ^ b;
    m_crc = m_crc << 1;
    if (fb) m_crc = m_crc ^ ((m_w == 32) ? 32'h04C1_1DB7 : 32'h0000_1021);
    if (m_w == 16) m_crc = m_crc & 32'h0000_FFFF;
  endtask

  task automatic model_slot(input cmd_t k);
    exp_n = 0;
    exp_v = '0;
    if (!k.m) begin
      m_inframe = 0; m_infcs = 0; m_fidx = 0;
      if (k.f) begin exp_tag = "R8 abort"; put_byte(8'h7F, 0); put_byte(8'h7E, 0); end
      else begin exp_tag = "R1 idle flag"; put_byte(8'h7E, 0); end
    end else if (m_inframe && (k.f || m_infcs)) begin
      for (int j = 0; j < 8; j++) put(~m_crc[m_w-1-(m_fidx*8+j)], 1);
      m_fidx++;
      m_infcs = 1;
      exp_tag = (m_w == 32) ? "R6 R11 fcs32 byte" : "R5 R11 fcs16 byte";
      if (m_fidx == m_w / 8) begin
        put_byte(8'h7E, 0);
        exp_tag = {exp_tag, " R7 closing flag"};
        m_inframe = 0; m_infcs = 0; m_fidx = 0;
      end
    end else begin
      if (!m_inframe) begin
        m_w = k.s ? 32 : 16;
        m_crc = k.s ? 32'hFFFF_FFFF : 32'h0000_FFFF;
        m_inframe = 1;
        exp_tag = "R2 first data byte";
      end else exp_tag = "R3 R4 data byte";
      for (int i = 0; i < 8; i++) begin
        crc_bit(k.d[i]);
        put(k.d[i], 1);
      end
    end
  endtask

  function automatic cmd_t mk(input logic m, input logic f, input logic s, input logic [7:0] d);
    cmd_t r;
    r.m = m; r.f = f; r.s = s; r.d = d;
    return r;
  endfunction

  task automatic add_idle(input int n);
    for (int i = 0; i < n; i++) cmds.push_back(mk(0, 0, 0, 8'h00));
  endtask

  task automatic add_frame(input int len, input bit w32, input int abort_at, input int kindp, input bit wiggle);
    logic [7:0] b;
    for (int i = 0; i < len; i++) begin
      if (i == abort_at) begin
        cmds.push_back(mk(0, 1, 0, 8'h00));
        return;
      end
      case (kindp)
        1: b = 8'hFF;
        2: b = 8'h7E;
        3: b = 8'(i * 37 + 1);
        default: b = ($urandom_range(0, 2) == 0) ? 8'hFF : 8'($urandom);
      endcase
      cmds.push_back(mk(1, 0, (i == 0 || !wiggle) ? w32 : 1'($urandom), b));
    end
    for (int i = 0; i < (w32 ? 4 : 2); i++)
      cmds.push_back(mk(1, 1, wiggle ? 1'($urandom) : w32, 8'h00));
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      chk(txd == 1'b1 && byte_req == 1'b0, "R10 reset outputs", {30'd0, txd, byte_req}, 32'd2);
    end else if (run && !done) begin
      cyc++;
      if (got_n < 32) got_v[got_n] = txd;
      got_n++;
      if (byte_req) begin
        chk(got_n == exp_n, "R9 request spacing", got_n, exp_n);
        chk(got_v == exp_v, exp_tag, got_v, exp_v);
        got_n = 0;
        got_v = '0;
        if (cmds.size() == 0) done = 1;
        else begin
          c = cmds.pop_front();
          msg_ctl = c.m; fcs_ctl = c.f; crc32_sel = c.s; din = c.d;
          model_slot(c);
        end
      end
      if (cyc > 150000) begin
        chk(0, "watchdog expired", cyc, 150000);
        done = 1;
      end
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    exp_v = {24'd0, 8'h7E};
    exp_n = 8;
    got_v = '0;
    exp_tag = "R10 flag after reset";
    add_idle(2);
    add_frame(3, 0, -1, 1, 0);
    add_idle(1);
    add_frame(4, 1, -1, 1, 0);
    add_frame(2, 0, -1, 2, 0);
    add_frame(1, 1, -1, 3, 0);
    add_idle(1);
    add_frame(5, 0, 2, 1, 0);
    add_idle(2);
    add_frame(6, 1, 3, 3, 0);
    add_frame(3, 1, -1, 3, 1);
    add_idle(1);
    for (int n = 0; n < 40; n++) begin
      int len;
      len = $urandom_range(1, 6);
      add_frame(len, 1'($urandom), ($urandom_range(0, 5) == 0) ? $urandom_range(0, len - 1) : -1,
                0, ($urandom_range(0, 2) == 0));
      add_idle($urandom_range(0, 2));
    end
    add_idle(2);
    repeat (3) @(negedge clk);
    #1;
    rst_n = 1'b1;
    run = 1'b1;
    wait (done);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule